// File: doc/BRIEF.md
# Ready/Valid Link Protocol Monitor

This block watches a single ready/valid link between a producer and a consumer without touching it. Every clock it samples the valid, ready and data signals. It reports each completed transfer on a strobe and counts the transfers in a saturating counter. The producer owns valid and the data. The consumer owns ready.

A mode input picks how strictly the link is judged. In plain decoupled mode either side may toggle its signals freely, so nothing is ever flagged. In irrevocable mode an offer, once made, is binding. A producer that has valid high while ready is low must keep valid high and the data unchanged until a transfer takes place. A broken offer sets one of two sticky error flags. The flags stay set until a synchronous reset or a one-cycle clear pulse.

The monitor is placed beside a link in a larger design or a test environment. Its flags and count are read as plain outputs.

Top module: `hs_link_monitor`

## Requirements
- R1: `xferStrobe` is high in exactly the cycles where `linkValid` and `linkReady` are both high. It is combinational, with no cycle of delay.
- R2: `xferCount` is zero after reset. It rises by one in the cycle after each transfer cycle.
- R3: `xferCount` stops at 16'hFFFF. Further transfers leave it at that value and do not wrap it to zero.
- R4: A stall cycle is a cycle with `linkValid` high and `linkReady` low. With `irrevMode` high, if a stall cycle is followed by a cycle whose `linkData` differs, `dataErr` is high from the next cycle on.
- R5: With `irrevMode` high, if a stall cycle is followed by a cycle with `linkValid` low, `dropErr` is high from the next cycle on.
- R6: With `irrevMode` low, the patterns of R4 and R5 are ignored. In decoupled mode `dataErr` and `dropErr` never rise.
- R7: Both error flags are sticky. A one-cycle `clrFlags` pulse clears them in the following cycle, and so does reset.
- R8: A `clrFlags` pulse in the same cycle as a new violation leaves that flag set.
- R9: `linkReady` may rise and fall while `linkValid` is low, in either mode. This raises no flag.
- R10: In irrevocable mode, a stalled offer whose valid and data stay stable until it is accepted raises no flag.
- R11: During and right after a synchronous active-high reset, `xferCount`, `dataErr` and `dropErr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irrevMode | input | 1 | 1 = irrevocable rules checked, 0 = plain decoupled |
| clrFlags | input | 1 | One-cycle pulse that clears both error flags |
| linkValid | input | 1 | Observed producer valid |
| linkReady | input | 1 | Observed consumer ready |
| linkData | input | DATA_W | Observed producer data |
| xferStrobe | output | 1 | High in every transfer cycle |
| xferCount | output | CNT_W | Saturating count of transfers |
| dataErr | output | 1 | Sticky flag: data changed during a stall |
| dropErr | output | 1 | Sticky flag: valid withdrawn during a stall |

## Verification
The hardest case to reach is the counter's saturation point, which needs 65535 transfers. The stimulus holds valid and ready high for a long unbroken run and keeps checking past the limit. A clear that lands on the same edge as a fresh violation is also timed on purpose, and the decoupled replay feeds the identical bad patterns to show they are ignored. The reference model in the bench tracks the stall state and the held data on its own and is compared every cycle.

// File: rtl/hsmon_pkg.sv
package hsmon_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic captureData;  // latch data of a stalled offer
    logic countEn;      // a transfer happened this cycle
  } hsmon_strobe_t;
endpackage

// File: rtl/hsmon_ctrl.sv
module hsmon_ctrl
  import hsmon_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          irrevMode,
  input  logic          clrFlags,
  input  logic          linkValid,
  input  logic          linkReady,
  input  logic          dataMismatch,
  output hsmon_strobe_t strobes,
  output logic          xferStrobe,
  output logic          dataErr,
  output logic          dropErr
);
  logic pending;
  logic dataViol;
  logic dropViol;

  assign xferStrobe = linkValid & linkReady;
  assign strobes.countEn = xferStrobe;
  assign strobes.captureData = linkValid & ~linkReady;

  // A violation is only meaningful while an earlier offer is still open
  assign dataViol = irrevMode & pending & linkValid & dataMismatch;
  assign dropViol = irrevMode & pending & ~linkValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      dataErr <= 1'b0;
      dropErr <= 1'b0;
    end else begin
      pending <= linkValid & ~linkReady;
      dataErr <= (dataErr & ~clrFlags) | dataViol;
      dropErr <= (dropErr & ~clrFlags) | dropViol;
    end
  end

  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(irrevMode && pending && !linkValid)) |-> dropErr); // R5
  AST_DECOUPLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($rose(dataErr) || $rose(dropErr)) |-> $past(irrevMode)); // R6
  AST_STICKY_DATA: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dataErr) && !$past(clrFlags)) |-> dataErr); // R7
  AST_STICKY_DROP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dropErr) && !$past(clrFlags)) |-> dropErr); // R7
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pending) && $rose(dropErr)) |-> 1'b0); // R9
endmodule

// File: rtl/hsmon_dpath.sv
module hsmon_dpath
  import hsmon_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  hsmon_strobe_t     strobes,
  input  logic [DATA_W-1:0] linkData,
  output logic              dataMismatch,
  output logic [CNT_W-1:0]  xferCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DATA_W-1:0] heldData;

  always_ff @(posedge clk) begin
    if (rst) begin
      heldData <= '0;
    end else if (strobes.captureData) begin
      heldData <= linkData;
    end
  end

  assign dataMismatch = (heldData != linkData);

  always_ff @(posedge clk) begin
    if (rst) begin
      xferCount <= '0;
    end else if (strobes.countEn && (xferCount != CNT_MAX)) begin
      xferCount <= xferCount + 1'b1;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(strobes.countEn) && ($past(xferCount) != CNT_MAX))
      |-> (xferCount == CNT_W'($past(xferCount) + 1'b1))); // R2
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (xferCount >= $past(xferCount))); // R3
endmodule

// File: rtl/hs_link_monitor.sv
module hs_link_monitor
  import hsmon_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irrevMode,
  input  logic              clrFlags,
  input  logic              linkValid,
  input  logic              linkReady,
  input  logic [DATA_W-1:0] linkData,
  output logic              xferStrobe,
  output logic [CNT_W-1:0]  xferCount,
  output logic              dataErr,
  output logic              dropErr
);
  hsmon_strobe_t strobes;
  logic          dataMismatch;

  hsmon_ctrl ctrl_i (
    .clk(clk), .rst(rst), .irrevMode(irrevMode), .clrFlags(clrFlags),
    .linkValid(linkValid), .linkReady(linkReady), .dataMismatch(dataMismatch),
    .strobes(strobes), .xferStrobe(xferStrobe), .dataErr(dataErr), .dropErr(dropErr)
  );

  hsmon_dpath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dpath_i (
    .clk(clk), .rst(rst), .strobes(strobes), .linkData(linkData),
    .dataMismatch(dataMismatch), .xferCount(xferCount)
  );
endmodule

// File: tb/hs_link_monitor_tb_top.sv
module hs_link_monitor_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irrevMode = 1'b0, clrFlags = 1'b0, linkValid = 1'b0, linkReady = 1'b0;
  logic [31:0] linkData = '0;
  logic xferStrobe, dataErr, dropErr;
  logic [15:0] xferCount;

  int nVec = 0, nFail = 0, cycles = 0;
  // reference model state
  int mCnt = 0;
  bit mPend = 0, mDataErr = 0, mDropErr = 0;
  logic [31:0] mHeld = '0;
  logic [31:0] curData = 32'h100;

  always #5 clk = ~clk;

  hs_link_monitor dut_i (
    .clk(clk), .rst(rst), .irrevMode(irrevMode), .clrFlags(clrFlags),
    .linkValid(linkValid), .linkReady(linkReady), .linkData(linkData),
    .xferStrobe(xferStrobe), .xferCount(xferCount), .dataErr(dataErr), .dropErr(dropErr)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    nVec++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic chkRegs(input string tag);
    chk({tag, " R2 R3"}, "xferCount", int'(xferCount), mCnt);
    chk({tag, " R4"}, "dataErr", int'(dataErr), int'(mDataErr));
    chk({tag, " R5"}, "dropErr", int'(dropErr), int'(mDropErr));
  endtask

  task automatic step(input string tag, input bit v, input bit r,
                      input logic [31:0] d, input bit m, input bit c);
    bit dv, dr;
    @(negedge clk);
    chkRegs(tag);
    linkValid = v; linkReady = r; linkData = d; irrevMode = m; clrFlags = c;
    #1;
    chk({tag, " R1"}, "xferStrobe", int'(xferStrobe), int'(v && r));
    dv = m && mPend && v && (d != mHeld);
    dr = m && mPend && !v;
    mDataErr = (mDataErr && !c) || dv;
    mDropErr = (mDropErr && !c) || dr;
    if (v && r && mCnt != 65535) mCnt++;
    if (v && !r) mHeld = d;
    mPend = v && !r;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; linkValid = 0; linkReady = 0; clrFlags = 0;
    @(negedge clk);
    mCnt = 0; mPend = 0; mDataErr = 0; mDropErr = 0; mHeld = '0;
    chkRegs("R11");
    rst = 1'b0;
  endtask

  // Legal producer: holds valid and data until accepted
  task automatic legalStream(input string tag, input bit m, input int n);
    for (int i = 0; i < n; i++) begin
      bit r;
      r = (i % 3) != 0;
      step(tag, 1'b1, r, curData, m, 1'b0);
      if (r) curData = curData + 32'h11;
    end
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    nFail++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 200000);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    doReset();
    // legal irrevocable stream with back-pressure
    legalStream("R10", 1'b1, 24);
    // ready toggling while valid low
    for (int i = 0; i < 6; i++) step("R9", 1'b0, i[0], 32'hDEAD0000 + i, 1'b1, 1'b0);
    // data change while stalled
    step("R4", 1'b1, 1'b0, 32'hA5, 1'b1, 1'b0);
    step("R4", 1'b1, 1'b0, 32'h5A, 1'b1, 1'b0);
    step("R4", 1'b1, 1'b1, 32'h5A, 1'b1, 1'b0);
    step("R7", 1'b0, 1'b0, 32'h0, 1'b1, 1'b0);
    step("R7", 1'b0, 1'b0, 32'h0, 1'b1, 1'b1);
    step("R7", 1'b0, 1'b0, 32'h0, 1'b1, 1'b0);
    // valid drop while stalled
    step("R5", 1'b1, 1'b0, 32'h77, 1'b1, 1'b0);
    step("R5", 1'b0, 1'b0, 32'h77, 1'b1, 1'b0);
    step("R5", 1'b0, 1'b1, 32'h77, 1'b1, 1'b0);
    step("R5", 1'b0, 1'b0, 32'h77, 1'b1, 1'b0);
    // clear coinciding with a new data violation
    step("R8", 1'b1, 1'b0, 32'h10, 1'b1, 1'b0);
    step("R8", 1'b1, 1'b0, 32'h11, 1'b1, 1'b1);
    step("R8", 1'b1, 1'b1, 32'h11, 1'b1, 1'b0);
    step("R8", 1'b0, 1'b0, 32'h0, 1'b1, 1'b1);
    step("R8", 1'b0, 1'b0, 32'h0, 1'b1, 1'b0);
    // same violations in decoupled mode
    step("R6", 1'b1, 1'b0, 32'hA5, 1'b0, 1'b0);
    step("R6", 1'b1, 1'b0, 32'h5A, 1'b0, 1'b0);
    step("R6", 1'b0, 1'b0, 32'h5A, 1'b0, 1'b0);
    step("R6", 1'b1, 1'b0, 32'h3C, 1'b0, 1'b0);
    step("R6", 1'b0, 1'b1, 32'h3C, 1'b0, 1'b0);
    step("R6", 1'b1, 1'b1, 32'h3C, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step("R9", 1'b0, i[0], 32'h0, 1'b0, 1'b0);
    legalStream("R6", 1'b0, 9);
    // saturation
    doReset();
    for (int i = 0; i < 65540; i++) step("R3", 1'b1, 1'b1, i, 1'b1, 1'b0);
    step("R3", 1'b0, 1'b0, 32'h0, 1'b1, 1'b0);
    @(negedge clk);
    chkRegs("R3");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule